// File: doc/BRIEF.md
# Configuration Access Header Generator

This block sits between a CPU-side register bus and the outbound request path of a PCIe root port. It turns plain 32-bit register accesses into configuration requests. Software first writes a target header register with the bus number, the device/function number and optional byte enables. It then reads or writes a location inside a fixed configuration data window. Each window access becomes exactly one outbound request record. The record's target comes from the latched header and its register offset comes from the window address.

The window access always moves a whole 32-bit word. Software derives the byte enables for a 1-, 2- or 4-byte access at offset `where` as ((1<<N)-1) << where[1:0], truncated to four bits. It places sub-word write data on its byte lanes by shifting left by 8×where[1:0] before the write. The block holds at most one request in flight. A window access stalls the register bus until the completion returns. An error completion yields all-ones read data.

Top module: `cfg_hdr_gen`

## Requirements
- R1: A write to bus address 0x140 latches the header with devfn in bits [7:0], bus number in bits [15:8], byte enables in bits [19:16] and the force flag in bit 20. A read of 0x140 returns that header with bits [31:21] zero. After reset the header reads as zero.
- R2: A read or write strobe at an address in 0x1000..0x1FFF, made while idle, produces exactly one cycle of `req_valid` on the cycle after the strobe is first sampled. The request carries the bus number and devfn of the latest header.
- R3: `req_offset` equals the address minus 0x1000 with its two low bits cleared.
- R4: With the header force flag set, `req_be` equals the header byte enables. With it clear, `req_be` is 4'b1111.
- R5: A window write gives `req_write`=1 and passes `req_data` = `reg_wdata` unchanged, already lane-placed. A window read gives `req_write`=0 and `req_data`=0.
- R6: `reg_ready` stays low from the window strobe until the completion is accepted. It is high in the cycle after `cpl_valid`. Header and other accesses are ready in the same cycle.
- R7: A completion with status 2'b00 (success) returns `cpl_data` on `reg_rdata`. Status 2'b01 (unsupported request), 2'b10 (timeout) or 2'b11 returns 32'hFFFF_FFFF.
- R8: `cpl_valid` while no request is outstanding is ignored. It produces no request, no ready and no change to the header.
- R9: Reads of addresses outside the header and the window return 0. Writes to those addresses leave the header unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (13) | Register bus byte address |
| reg_wdata | input | 32 | Register bus write data |
| reg_wr | input | 1 | Write strobe, held until ready |
| reg_rd | input | 1 | Read strobe, held until ready |
| reg_rdata | output | 32 | Read data, valid with ready |
| reg_ready | output | 1 | Access completes this cycle |
| req_valid | output | 1 | One-cycle request pulse |
| req_bus | output | 8 | Target bus number |
| req_devfn | output | 8 | Target device/function |
| req_offset | output | WIN_LOG2 (12) | Dword-aligned register offset |
| req_be | output | 4 | Byte enables |
| req_write | output | 1 | 1 for write request |
| req_data | output | 32 | Write payload |
| cpl_valid | input | 1 | Completion returned |
| cpl_status | input | 2 | Completion status |
| cpl_data | input | 32 | Completion data |

## Verification
The bench targets the sub-word write at a non-zero lane. There, a design that shifted the data again or ignored the force flag would show the wrong lanes or byte enables. It also sends a completion on the same cycle the request appears and another after a long wait. A controller that only listened in one state would hang or take the completion early. A stray completion while idle must not release a later access. Each error status must give all ones, so a design that passed data through on unsupported-request or timeout would show the raw completion word.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

   // Header layout; packed order fixes the bit positions software uses.
   typedef struct packed {
      logic       force_be;   // [20]
      logic [3:0] be;         // [19:16]
      logic [7:0] bus;        // [15:8]
      logic [7:0] devfn;      // [7:0]
   } cfg_hdr_t;

   localparam int unsigned HDR_BITS = $bits(cfg_hdr_t);

   typedef enum logic [1:0] {
      CPL_OK  = 2'b00,
      CPL_UR  = 2'b01,
      CPL_TMO = 2'b10,
      CPL_RSV = 2'b11
   } cpl_stat_e;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_ISSUE,
      TX_WAIT,
      TX_DONE
   } txn_st_e;

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned HDR_ADDR = 'h140,
   parameter int unsigned WIN_BASE = 'h1000,
   parameter int unsigned WIN_LOG2 = 12
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic                hit_hdr,
   output logic                hit_win,
   output logic [WIN_LOG2-1:0] win_off
);
   localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;
   localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE >> WIN_LOG2);

   always_comb begin
      hit_hdr = (addr == ADDR_W'(HDR_ADDR));
      hit_win = (addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
      win_off = addr[WIN_LOG2-1:0];
   end
endmodule

// File: rtl/cfg_hdr_reg.sv
module cfg_hdr_reg
   import cfg_hdr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  logic [31:0] wdata,
   output cfg_hdr_t hdr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hdr_q <= '0;
      else if (wr_en)
         hdr_q <= cfg_hdr_t'(wdata[HDR_BITS-1:0]);
   end
endmodule

// File: rtl/cfg_req_build.sv
module cfg_req_build
   import cfg_hdr_pkg::*;
#(
   parameter int unsigned OFF_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  cfg_hdr_t         hdr,
   input  logic [OFF_W-1:0] win_off,
   input  logic             is_write,
   input  logic [31:0]      wdata,
   output logic [7:0]       req_bus,
   output logic [7:0]       req_devfn,
   output logic [OFF_W-1:0] req_offset,
   output logic [3:0]       req_be,
   output logic             req_write,
   output logic [31:0]      req_data
);
   logic [3:0]       be_sel;
   logic [OFF_W-1:0] off_aligned;

   always_comb begin
      be_sel      = hdr.force_be ? hdr.be : 4'b1111;
      off_aligned = {win_off[OFF_W-1:2], 2'b00};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_bus    <= '0;
         req_devfn  <= '0;
         req_offset <= '0;
         req_be     <= '0;
         req_write  <= 1'b0;
         req_data   <= '0;
      end else if (load) begin
         req_bus    <= hdr.bus;
         req_devfn  <= hdr.devfn;
         req_offset <= off_aligned;
         req_be     <= be_sel;
         req_write  <= is_write;
         req_data   <= is_write ? wdata : 32'h0;
      end
   end
endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
   import cfg_hdr_pkg::*;
#(
   parameter bit ERR_ALL_ONES = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        cpl_valid,
   input  logic [1:0]  cpl_status,
   input  logic [31:0] cpl_data,
   output logic        idle,
   output logic        issue,
   output logic        done,
   output logic [31:0] rdata_q
);
   txn_st_e     st_q, st_d;
   logic        cpl_take;
   logic [31:0] fill_data;

   always_comb begin
      idle     = (st_q == TX_IDLE);
      issue    = (st_q == TX_ISSUE);
      done     = (st_q == TX_DONE);
      cpl_take = cpl_valid && (st_q == TX_ISSUE || st_q == TX_WAIT);
   end

   generate
      if (ERR_ALL_ONES) begin : g_err_ones
         always_comb fill_data = (cpl_status == CPL_OK) ? cpl_data : 32'hFFFF_FFFF;
      end else begin : g_err_pass
         always_comb fill_data = cpl_data;
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         TX_IDLE:  if (start) st_d = TX_ISSUE;
         TX_ISSUE: st_d = cpl_take ? TX_DONE : TX_WAIT;
         TX_WAIT:  if (cpl_take) st_d = TX_DONE;
         TX_DONE:  st_d = TX_IDLE;
         default:  st_d = TX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TX_IDLE;
         rdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (cpl_take) rdata_q <= fill_data;
      end
   end

   // R2
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !issue);

   // R7
   err_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_take && cpl_status != 2'b00 && ERR_ALL_ONES) |=> (done && rdata_q == 32'hFFFF_FFFF));

   // R8
   idle_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !start) |=> idle);
endmodule

// File: rtl/cfg_hdr_gen.sv
module cfg_hdr_gen
   import cfg_hdr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 13,
   parameter int unsigned HDR_ADDR     = 'h140,
   parameter int unsigned WIN_BASE     = 'h1000,
   parameter int unsigned WIN_LOG2     = 12,
   parameter bit          ERR_ALL_ONES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   input  logic                reg_wr,
   input  logic                reg_rd,
   output logic [31:0]         reg_rdata,
   output logic                reg_ready,
   output logic                req_valid,
   output logic [7:0]          req_bus,
   output logic [7:0]          req_devfn,
   output logic [WIN_LOG2-1:0] req_offset,
   output logic [3:0]          req_be,
   output logic                req_write,
   output logic [31:0]         req_data,
   input  logic                cpl_valid,
   input  logic [1:0]          cpl_status,
   input  logic [31:0]         cpl_data
);
   localparam int unsigned PAD_W = 32 - HDR_BITS;

   generate
      if (WIN_LOG2 < 3 || WIN_LOG2 >= ADDR_W)
         $error("WIN_LOG2 must lie between 3 and ADDR_W-1");
      if ((WIN_BASE % (1 << WIN_LOG2)) != 0)
         $error("WIN_BASE must be aligned to the window size");
      if (HDR_ADDR >= (1 << ADDR_W))
         $error("HDR_ADDR does not fit in ADDR_W");
   endgenerate

   logic                hit_hdr, hit_win;
   logic [WIN_LOG2-1:0] win_off;
   logic                win_stb, start, hdr_we;
   logic                idle, issue, done;
   logic [31:0]         cpl_rdata;
   cfg_hdr_t            hdr_q;

   cfg_addr_dec #(
      .ADDR_W(ADDR_W), .HDR_ADDR(HDR_ADDR),
      .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)
   ) u_dec (
      .addr(reg_addr), .hit_hdr(hit_hdr), .hit_win(hit_win), .win_off(win_off)
   );

   always_comb begin
      win_stb = (reg_wr || reg_rd) && hit_win;
      start   = win_stb && idle;
      hdr_we  = reg_wr && hit_hdr && idle;
   end

   cfg_hdr_reg u_hdr (
      .clk(clk), .rst_n(rst_n), .wr_en(hdr_we), .wdata(reg_wdata), .hdr_q(hdr_q)
   );

   cfg_req_build #(.OFF_W(WIN_LOG2)) u_build (
      .clk(clk), .rst_n(rst_n), .load(start), .hdr(hdr_q),
      .win_off(win_off), .is_write(reg_wr), .wdata(reg_wdata),
      .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
      .req_be(req_be), .req_write(req_write), .req_data(req_data)
   );

   cfg_txn_ctrl #(.ERR_ALL_ONES(ERR_ALL_ONES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data),
      .idle(idle), .issue(issue), .done(done), .rdata_q(cpl_rdata)
   );

   always_comb begin
      req_valid = issue;
      reg_ready = done || (idle && !win_stb);
      if (done)
         reg_rdata = cpl_rdata;
      else if (hit_hdr)
         reg_rdata = {{PAD_W{1'b0}}, hdr_q};
      else
         reg_rdata = 32'h0;
   end

   // R6
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !reg_ready);

   // R2
   hdr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_bus == hdr_q.bus && req_devfn == hdr_q.devfn));

   // R6
   start_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_stb && idle) |-> !reg_ready);
endmodule

// File: tb/tb_cfg_hdr_gen.sv
module tb_cfg_hdr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic        reg_ready;
   logic        req_valid;
   logic [7:0]  req_bus, req_devfn;
   logic [11:0] req_offset;
   logic [3:0]  req_be;
   logic        req_write;
   logic [31:0] req_data;
   logic        cpl_valid = 1'b0;
   logic [1:0]  cpl_status = '0;
   logic [31:0] cpl_data = '0;

   int checks = 0, errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   cfg_hdr_gen dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] be_of(input int n, input int where);
      logic [7:0] m;
      m = ((8'd1 << n) - 8'd1) << (where & 3);
      return m[3:0];
   endfunction

   task automatic hdr_write(input logic [31:0] v);
      @(negedge clk);
      reg_addr = 13'h140; reg_wdata = v; reg_wr = 1'b1;
      chk("R6 header write ready", {31'b0, reg_ready}, 32'd1);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic hdr_read(input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = 13'h140; reg_rd = 1'b1;
      #1;
      chk(tag, reg_rdata, exp);
      chk("R6 header read ready", {31'b0, reg_ready}, 32'd1);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // One window access with the full expectation set.
   task automatic win_access(input bit wr, input logic [11:0] off, input logic [31:0] wd,
                             input int delay, input logic [1:0] st, input logic [31:0] cd,
                             input logic [7:0] e_bus, input logic [7:0] e_devfn,
                             input logic [3:0] e_be, input logic [31:0] e_rdata);
      @(negedge clk);
      reg_addr = 13'h1000 | {1'b0, off}; reg_wdata = wd;
      reg_wr = wr; reg_rd = !wr;
      #1;
      chk("R6 stall on strobe", {31'b0, reg_ready}, 32'd0);
      chk("R2 no request same cycle", {31'b0, req_valid}, 32'd0);
      @(negedge clk);
      chk("R2 request pulse", {31'b0, req_valid}, 32'd1);
      chk("R2 bus", {24'b0, req_bus}, {24'b0, e_bus});
      chk("R2 devfn", {24'b0, req_devfn}, {24'b0, e_devfn});
      chk("R3 offset", {20'b0, req_offset}, {20'b0, off & 12'hFFC});
      chk("R4 byte enables", {28'b0, req_be}, {28'b0, e_be});
      chk("R5 direction", {31'b0, req_write}, {31'b0, wr});
      chk("R5 data", req_data, wr ? wd : 32'h0);
      chk("R6 stall while pending", {31'b0, reg_ready}, 32'd0);
      for (int i = 0; i < delay; i++) begin
         @(negedge clk);
         chk("R2 single pulse", {31'b0, req_valid}, 32'd0);
         chk("R6 stall waiting", {31'b0, reg_ready}, 32'd0);
      end
      cpl_valid = 1'b1; cpl_status = st; cpl_data = cd;
      @(negedge clk);
      cpl_valid = 1'b0;
      chk("R6 ready after completion", {31'b0, reg_ready}, 32'd1);
      chk("R7 read data", reg_rdata, e_rdata);
      reg_wr = 1'b0; reg_rd = 1'b0;
      @(negedge clk);
      chk("R2 back to idle", {31'b0, req_valid}, 32'd0);
   endtask

   task automatic t_reset;
      #1;
      chk("R9 reset no request", {31'b0, req_valid}, 32'd0);
      hdr_read(32'h0, "R1 header after reset");
   endtask

   task automatic t_header;
      hdr_write(32'hFFFF_FFFF);
      hdr_read(32'h001F_FFFF, "R1 header upper bits zero");
      hdr_write(32'h0013_2A45);
      hdr_read(32'h0013_2A45, "R1 header fields");
   endtask

   task automatic t_full_read;
      hdr_write({11'b0, 1'b0, 4'b0010, 8'h05, 8'h18});
      win_access(1'b0, 12'h010, 32'h0, 0, 2'b00, 32'hCAFE_0001, 8'h05, 8'h18, 4'hF, 32'hCAFE_0001);
      win_access(1'b0, 12'hFFF, 32'h0, 5, 2'b00, 32'h1234_5678, 8'h05, 8'h18, 4'hF, 32'h1234_5678);
   endtask

   task automatic t_subword_write;
      logic [3:0] be;
      be = be_of(2, 2);
      hdr_write({11'b0, 1'b1, be, 8'h01, 8'h08});
      win_access(1'b1, 12'h046, 32'h0000_ABCD << 16, 1, 2'b00, 32'h0,
                 8'h01, 8'h08, 4'b1100, 32'h0);
      be = be_of(1, 3);
      hdr_write({11'b0, 1'b1, be, 8'h02, 8'h09});
      win_access(1'b1, 12'h103, 32'h0000_005A << 24, 0, 2'b00, 32'h0,
                 8'h02, 8'h09, 4'b1000, 32'h0);
      be = be_of(4, 0);
      hdr_write({11'b0, 1'b1, be, 8'h03, 8'h0A});
      win_access(1'b1, 12'h200, 32'hDEAD_BEEF, 2, 2'b00, 32'h0,
                 8'h03, 8'h0A, 4'b1111, 32'h0);
   endtask

   task automatic t_errors;
      hdr_write({11'b0, 1'b1, 4'b0001, 8'h7F, 8'hFF});
      win_access(1'b0, 12'h000, 32'h0, 1, 2'b01, 32'h1111_2222, 8'h7F, 8'hFF, 4'b0001, 32'hFFFF_FFFF);
      win_access(1'b0, 12'h004, 32'h0, 3, 2'b10, 32'h3333_4444, 8'h7F, 8'hFF, 4'b0001, 32'hFFFF_FFFF);
      win_access(1'b0, 12'h008, 32'h0, 0, 2'b11, 32'h0, 8'h7F, 8'hFF, 4'b0001, 32'hFFFF_FFFF);
   endtask

   task automatic t_stray_cpl;
      hdr_write(32'h0000_1234);
      @(negedge clk);
      reg_addr = 13'h0; cpl_valid = 1'b1; cpl_status = 2'b00; cpl_data = 32'h5555_5555;
      @(negedge clk);
      @(negedge clk);
      cpl_valid = 1'b0;
      chk("R8 stray completion no request", {31'b0, req_valid}, 32'd0);
      chk("R8 stray completion read data", reg_rdata, 32'h0);
      hdr_read(32'h0000_1234, "R8 header untouched");
      win_access(1'b0, 12'h020, 32'h0, 2, 2'b00, 32'h0BAD_F00D, 8'h12, 8'h34, 4'hF, 32'h0BAD_F00D);
   endtask

   task automatic t_other_addr;
      hdr_write(32'h0000_0101);
      @(negedge clk);
      reg_addr = 13'h0144; reg_wdata = 32'hFFFF_FFFF; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 13'h0800;
      #1;
      chk("R9 other read zero", reg_rdata, 32'h0);
      chk("R9 other ready", {31'b0, reg_ready}, 32'd1);
      chk("R9 no request", {31'b0, req_valid}, 32'd0);
      @(negedge clk);
      reg_rd = 1'b0;
      hdr_read(32'h0000_0101, "R9 header untouched");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_header();
      t_full_read();
      t_subword_write();
      t_errors();
      t_stray_cpl();
      t_other_addr();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule